// File: doc/BRIEF.md
# Randomized-Window Modular Exponentiator

This block raises a base C to an exponent d modulo N. It scans the exponent from the most significant bit downwards, one window at a time. Before each window a pseudo-random generator picks a width of one, two or three bits. The accumulator is then squared once per bit in the window and multiplied by a stored power of C, selected by the window's bit value. Because the width is redrawn for every window, two identical requests generally take different numbers of cycles and go through different intermediate values. The result does not change.

Squarings, window products and the table set-up all share one bit-serial modular multiplier, and the same operand path feeds it in every case. After a start pulse the block first builds a table of C^1 to C^7 reduced modulo N. It then walks the exponent with a shrinking count of remaining bits. When the last bit has been used it raises a one-cycle done pulse, and the result stays on its output until the next start. The random generator's seed can be loaded from outside, so a given sequence of window widths can be replayed exactly.

Top module: `modexp_randwin`

## Requirements
- R1: For any modulus N of at least 2 and any base and exponent, including a base of N or more, the result after done equals base^exponent mod N.
- R2: An exponent of 0 gives 1, and an exponent of 1 gives the base reduced modulo N. The power table is built before the first exponent bit is used.
- R3: Each window width is one of 1, 2 or 3. It is lowered to the number of exponent bits still unprocessed whenever the drawn width is larger.
- R4: Every window performs exactly as many squarings as its width and then one multiplication, even when the window's digit is zero (digit zero multiplies by 1). As a result, the start-to-done latency depends only on the seed and never on the exponent value.
- R5: Two runs from the same loaded seed have identical latency. Different seeds produce different latencies for the same operands.
- R6: done is high for exactly one cycle per run. result keeps its value while idle, even when the inputs change, until the next accepted start.
- R7: start is ignored while busy is high, and this includes the cycle in which done is high.
- R8: After reset, busy, done and result are all 0.
- R9: The shared multiplier is never issued a new operation while it is still working on one.
- R10: Loading a seed of 0 is replaced by a nonzero seed, so runs still finish correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle; base, expo and modulus are captured in that cycle |
| seedLoad | input | 1 | Loads seedVal into the window-width generator |
| seedVal | input | 16 | Seed value; 0 is replaced by 1 |
| base | input | 16 | Base C, any value |
| expo | input | 16 | Exponent d |
| modulus | input | 16 | Modulus N, must be at least 2 |
| busy | output | 1 | High from the cycle after an accepted start up to and including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Accumulator: C^d mod N after done, held while idle |

## Verification
Two events can share a cycle here: a new start request and the completion of the current run, since done is raised while the controller still counts as busy. The bench provokes this by holding start high in exactly the cycle it sees done. It then checks that the block returns to idle instead of launching a new run, and that the finished result is still correct afterwards. A separate start pulse in the middle of a run is checked the same way: the returned value must belong to the first operand set.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  typedef enum logic [1:0] {
    OP_LOADC = 2'd0,  // 1 * C          -> table[1]
    OP_PWR   = 2'd1,  // table[i-1] * table[1] -> table[i]
    OP_SQR   = 2'd2,  // acc * acc
    OP_WIN   = 2'd3   // table[digit] * acc
  } mulOpT;

  typedef struct packed {
    logic       mulGo;
    mulOpT      opSel;
    logic       tabWr;
    logic [2:0] tabIdx;
    logic       accInit;
    logic       accWr;
    logic       expLoad;
    logic       expShift;
    logic [1:0] shiftAmt;
  } ctrlBusT;

endpackage

// File: rtl/modmul_seq.sv
module modmul_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] modN,
  output logic [W-1:0] prod,
  output logic         fin,
  output logic         busy
);
  localparam int CW = $clog2(W + 1);
  localparam int XW = W + 2;

  logic [W-1:0]  accR, aR, bR, nR;
  logic [CW-1:0] cnt;
  logic          runR, finR;

  logic [XW-1:0] dbl, dblRed, sum, sumRed, nExt, aExt;

  always_comb begin
    nExt   = {2'b00, nR};
    aExt   = {2'b00, aR};
    dbl    = {1'b0, accR, 1'b0};
    dblRed = (dbl >= nExt) ? dbl - nExt : dbl;
    sum    = dblRed + (bR[W-1] ? aExt : '0);
    sumRed = (sum >= nExt) ? sum - nExt : sum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR <= '0;
      aR   <= '0;
      bR   <= '0;
      nR   <= '0;
      cnt  <= '0;
      runR <= 1'b0;
      finR <= 1'b0;
    end else begin
      finR <= 1'b0;
      if (go && !runR) begin
        aR   <= opA;
        bR   <= opB;
        nR   <= modN;
        accR <= '0;
        cnt  <= CW'(W);
        runR <= 1'b1;
      end else if (runR) begin
        accR <= sumRed[W-1:0];
        bR   <= bR << 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          runR <= 1'b0;
          finR <= 1'b1;
        end
      end
    end
  end

  assign prod = accR;
  assign fin  = finR;
  assign busy = runR;

endmodule

// File: rtl/modexp_datapath.sv
module modexp_datapath
  import modexp_pkg::*;
#(
  parameter int W  = 16,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlBusT       cb,
  input  logic [W-1:0]  base,
  input  logic [EW-1:0] expo,
  input  logic [W-1:0]  modulus,
  output logic [W-1:0]  result,
  output logic          mulFin,
  output logic          mulBusy
);
  localparam int TABN = 8;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0]  accR, cR, nR;
  logic [EW-1:0] expR;
  logic [W-1:0]  tab [1:TABN-1];
  logic [2:0]    digit;
  logic [W-1:0]  opA, opB, mulProd, winVal, prevVal;

  // window digit taken from the top of the exponent register
  always_comb begin
    case (cb.shiftAmt)
      2'd1:    digit = {2'b00, expR[EW-1]};
      2'd2:    digit = {1'b0, expR[EW-1:EW-2]};
      2'd3:    digit = expR[EW-1:EW-3];
      default: digit = 3'd0;
    endcase
  end

  always_comb begin
    winVal  = (digit == 3'd0) ? ONE : tab[digit];
    prevVal = (cb.tabIdx <= 3'd1) ? ONE : tab[cb.tabIdx - 3'd1];
    case (cb.opSel)
      OP_LOADC: begin opA = ONE;     opB = cR;     end
      OP_PWR:   begin opA = prevVal; opB = tab[1]; end
      OP_SQR:   begin opA = accR;    opB = accR;   end
      default:  begin opA = winVal;  opB = accR;   end
    endcase
  end

  modmul_seq #(.W(W)) uMul (
    .clk  (clk),
    .rstN (rstN),
    .go   (cb.mulGo),
    .opA  (opA),
    .opB  (opB),
    .modN (nR),
    .prod (mulProd),
    .fin  (mulFin),
    .busy (mulBusy)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR <= '0;
      cR   <= '0;
      nR   <= '0;
      expR <= '0;
      for (int i = 1; i < TABN; i++) tab[i] <= '0;
    end else begin
      if (cb.expLoad) begin
        expR <= expo;
        cR   <= base;
        nR   <= modulus;
      end else if (cb.expShift) begin
        expR <= expR << cb.shiftAmt;
      end
      if (cb.accInit)    accR <= ONE;
      else if (cb.accWr) accR <= mulProd;
      if (cb.tabWr) begin
        for (int i = 1; i < TABN; i++)
          if (cb.tabIdx == 3'(i)) tab[i] <= mulProd;
      end
    end
  end

  assign result = accR;

endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
  import modexp_pkg::*;
#(
  parameter int          EW   = 16,
  parameter int          LW   = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  localparam int         RW   = $clog2(EW + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          seedLoad,
  input  logic [LW-1:0] seedVal,
  input  logic          mulFin,
  output ctrlBusT       cb,
  output logic          busy,
  output logic          done,
  output logic [1:0]    winW,
  output logic [RW-1:0] remBits
);
  typedef enum logic [3:0] {
    S_IDLE, S_PREGO, S_PREWAIT, S_DRAW, S_SQGO, S_SQWAIT, S_WGO, S_WWAIT, S_DONE
  } stateT;

  stateT         st;
  logic [2:0]    preIdx;
  logic [RW-1:0] remR;
  logic [1:0]    winR, sqLeft, drawW, clampW;
  logic [LW-1:0] lfsr, lfsrNext;

  always_comb begin
    lfsrNext = (lfsr >> 1) ^ (lfsr[0] ? TAPS : '0);
    drawW    = (lfsr[1:0] == 2'd3) ? 2'd2 : lfsr[1:0] + 2'd1;
    clampW   = ({{(RW-2){1'b0}}, drawW} > remR) ? remR[1:0] : drawW;
  end

  always_comb begin
    cb        = '0;
    cb.opSel  = OP_SQR;
    case (st)
      S_IDLE: if (start) begin
        cb.expLoad = 1'b1;
        cb.accInit = 1'b1;
      end
      S_PREGO: begin
        cb.mulGo  = 1'b1;
        cb.opSel  = (preIdx == 3'd1) ? OP_LOADC : OP_PWR;
        cb.tabIdx = preIdx;
      end
      S_PREWAIT: begin
        cb.tabIdx = preIdx;
        cb.tabWr  = mulFin;
      end
      S_SQGO:   cb.mulGo = 1'b1;
      S_SQWAIT: cb.accWr = mulFin;
      S_WGO: begin
        cb.mulGo    = 1'b1;
        cb.opSel    = OP_WIN;
        cb.shiftAmt = winR;
      end
      S_WWAIT: begin
        cb.opSel    = OP_WIN;
        cb.accWr    = mulFin;
        cb.expShift = mulFin;
        cb.shiftAmt = winR;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= S_IDLE;
      preIdx <= '0;
      remR   <= '0;
      winR   <= '0;
      sqLeft <= '0;
      lfsr   <= LW'(1);
    end else begin
      if (seedLoad)          lfsr <= (seedVal == '0) ? LW'(1) : seedVal;
      else if (st == S_DRAW) lfsr <= lfsrNext;
      case (st)
        S_IDLE: if (start) begin
          preIdx <= 3'd1;
          remR   <= RW'(EW);
          st     <= S_PREGO;
        end
        S_PREGO: st <= S_PREWAIT;
        S_PREWAIT: if (mulFin) begin
          if (preIdx == 3'd7) st <= S_DRAW;
          else begin
            preIdx <= preIdx + 3'd1;
            st     <= S_PREGO;
          end
        end
        S_DRAW: begin
          winR   <= clampW;
          sqLeft <= clampW;
          st     <= S_SQGO;
        end
        S_SQGO: st <= S_SQWAIT;
        S_SQWAIT: if (mulFin) begin
          sqLeft <= sqLeft - 2'd1;
          st     <= (sqLeft == 2'd1) ? S_WGO : S_SQGO;
        end
        S_WGO: st <= S_WWAIT;
        S_WWAIT: if (mulFin) begin
          remR <= remR - {{(RW-2){1'b0}}, winR};
          st   <= (remR == {{(RW-2){1'b0}}, winR}) ? S_DONE : S_DRAW;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_DONE);
  assign winW    = winR;
  assign remBits = remR;

endmodule

// File: rtl/modexp_randwin.sv
module modexp_randwin
  import modexp_pkg::*;
#(
  parameter int            W    = 16,
  parameter int            EW   = 16,
  parameter int            LW   = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          seedLoad,
  input  logic [LW-1:0] seedVal,
  input  logic [W-1:0]  base,
  input  logic [EW-1:0] expo,
  input  logic [W-1:0]  modulus,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  result
);
  localparam int RW = $clog2(EW + 1);

  ctrlBusT       cb;
  logic          mulFin, mulBusy;
  logic [1:0]    winW;
  logic [RW-1:0] remBits;

  modexp_ctrl #(.EW(EW), .LW(LW), .TAPS(TAPS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .seedLoad (seedLoad),
    .seedVal  (seedVal),
    .mulFin   (mulFin),
    .cb       (cb),
    .busy     (busy),
    .done     (done),
    .winW     (winW),
    .remBits  (remBits)
  );

  modexp_datapath #(.W(W), .EW(EW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .cb      (cb),
    .base    (base),
    .expo    (expo),
    .modulus (modulus),
    .result  (result),
    .mulFin  (mulFin),
    .mulBusy (mulBusy)
  );

endmodule

// File: rtl/modexp_randwin_chk.sv
module modexp_randwin_chk
  import modexp_pkg::*;
#(
  parameter int EW = 16,
  localparam int RW = $clog2(EW + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input ctrlBusT       cb,
  input logic          mulFin,
  input logic          mulBusy,
  input logic [1:0]    winW,
  input logic [RW-1:0] remBits
);
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (cb.mulGo && cb.opSel == OP_WIN) |-> (winW != 2'd0 && {{(RW-2){1'b0}}, winW} <= remBits)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy); // R7

  AST_MUL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    cb.mulGo |-> !mulBusy); // R9

  AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    mulFin |=> !mulFin); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cb.mulGo); // R9

endmodule

bind modexp_randwin modexp_randwin_chk #(.EW(EW)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .cb      (cb),
  .mulFin  (mulFin),
  .mulBusy (mulBusy),
  .winW    (winW),
  .remBits (remBits)
);

// File: tb/sim_modexp_randwin.sv
`timescale 1ns/1ps
module sim_modexp_randwin;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        seedLoad = 1'b0;
  logic [15:0] seedVal = '0;
  logic [15:0] base = '0, expo = '0, modulus = 16'd2;
  logic        busy, done;
  logic [15:0] result;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit timedOut = 0;

  always #2 clk = ~clk;

  modexp_randwin u0 (
    .clk(clk), .rstN(rstN), .start(start), .seedLoad(seedLoad), .seedVal(seedVal),
    .base(base), .expo(expo), .modulus(modulus),
    .busy(busy), .done(done), .result(result)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint refPow(longint b, longint e, longint n);
    longint r = 1 % n;
    longint bb = b % n;
    for (int i = 15; i >= 0; i--) begin
      r = (r * r) % n;
      if (e[i]) r = (r * bb) % n;
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic loadSeed(logic [15:0] s);
    @(negedge clk);
    seedVal  = s;
    seedLoad = 1'b1;
    @(negedge clk);
    seedLoad = 1'b0;
  endtask

  // runs one exponentiation; startAtDone raises start in the done cycle
  task automatic runExp(logic [15:0] b, logic [15:0] e, logic [15:0] n,
                        bit startAtDone, output logic [15:0] res, output int lat);
    int guard = 0;
    @(negedge clk);
    base = b; expo = e; modulus = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && guard < 20000) begin
      @(negedge clk);
      lat++; guard++;
    end
    if (startAtDone) begin
      base = b + 16'd3; expo = e ^ 16'h5A5A; start = 1'b1;
    end
    res = result;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R6 done one cycle", done, 0);
    if (startAtDone) check(busy == 1'b0, "R7 start in done cycle ignored", busy, 0);
  endtask

  initial begin
    logic [15:0] r, r2;
    int l1, l2, lz, lf;
    int lats[6];
    bit differ;
    int bb, ee, nn;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    check(busy == 0, "R8 busy after reset", busy, 0);
    check(done == 0, "R8 done after reset", done, 0);
    check(result == 0, "R8 result after reset", result, 0);
    rstN = 1'b1;

    // R1 known case, R5 reproducibility
    loadSeed(16'h00A5);
    runExp(16'd146, 16'd187, 16'd207, 0, r, l1);
    check(r == 16'd47, "R1 146^187 mod 207", r, 47);
    loadSeed(16'h00A5);
    runExp(16'd146, 16'd187, 16'd207, 0, r, l2);
    check(r == 16'd47, "R1 repeat", r, 47);
    check(l1 == l2, "R5 same seed same latency", l2, l1);

    differ = 0;
    for (int s = 0; s < 6; s++) begin
      loadSeed(16'(s * 7919 + 3));
      runExp(16'd146, 16'd187, 16'd207, 0, r, lats[s]);
      check(r == 16'd47, "R1 seed sweep", r, 47);
      if (s > 0 && lats[s] != lats[0]) differ = 1;
    end
    check(differ, "R5 latency varies across seeds", differ, 1);

    // R4 latency independent of exponent value
    loadSeed(16'h1357);
    runExp(16'd999, 16'h0000, 16'd1009, 0, r, lz);
    check(r == 16'd1, "R2 exponent zero", r, 1);
    loadSeed(16'h1357);
    runExp(16'd999, 16'hFFFF, 16'd1009, 0, r, lf);
    check(r == 16'(refPow(999, 65535, 1009)), "R1 all-ones exponent", r, refPow(999, 65535, 1009));
    check(lz == lf, "R4 latency independent of digits", lf, lz);

    // R2 exponent one, base above modulus
    runExp(16'd60000, 16'd1, 16'd207, 0, r, l1);
    check(r == 16'(60000 % 207), "R2 exponent one", r, 60000 % 207);
    runExp(16'hFFFF, 16'd12345, 16'd2, 0, r, l1);
    check(r == 16'(refPow(65535, 12345, 2)), "R1 modulus two", r, refPow(65535, 12345, 2));
    runExp(16'd5, 16'd3, 16'hFFFF, 0, r, l1);
    check(r == 16'd125, "R1 max modulus", r, 125);

    // R10 zero seed
    loadSeed(16'h0000);
    runExp(16'd146, 16'd187, 16'd207, 0, r, l1);
    check(r == 16'd47, "R10 zero seed run", r, 47);

    // R7 start at done and mid-run
    runExp(16'd123, 16'd4567, 16'd8191, 1, r, l1);
    check(r == 16'(refPow(123, 4567, 8191)), "R7 result with start at done", r, refPow(123, 4567, 8191));
    @(negedge clk);
    base = 16'd77; expo = 16'd777; modulus = 16'd7777; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (60) @(negedge clk);
    base = 16'd2; expo = 16'd2; modulus = 16'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    r = result;
    check(r == 16'(refPow(77, 777, 7777)), "R7 mid-run start ignored", r, refPow(77, 777, 7777));

    // R6 result held while idle
    base = 16'd1; expo = 16'd9; modulus = 16'd11;
    repeat (10) @(negedge clk);
    check(result == r, "R6 result held when idle", result, r);

    // R1 random
    for (int k = 0; k < 25; k++) begin
      nn = 2 + int'($urandom % 65534);
      bb = int'($urandom % 65536);
      ee = int'($urandom % 65536);
      if (k % 5 == 0) loadSeed(16'($urandom));
      runExp(16'(bb), 16'(ee), 16'(nn), 0, r2, l1);
      check(r2 == 16'(refPow(bb, ee, nn)), "R1 random", r2, refPow(bb, ee, nn));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule